// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface and owns the command pins while the memory is brought up and whenever a refresh is due. After reset it holds a no-operation command with clock enable and the data mask high for a stabilization window. It then closes every bank with a precharge-all, waits the row precharge time, and issues a programmable number of auto-refresh commands, each spaced by the refresh cycle time. Finally it loads the mode register from a 7-bit opcode input, waits the mode-register cycle time and raises `ready`.

In normal operation an interval counter produces one refresh obligation per refresh interval, set by default to 8192 refreshes per 64 ms. Obligations accumulate, up to a parameter limit, while they wait. The sequencer raises `ref_req`. The user port then closes its open banks and answers with `ref_gnt`. The sequencer issues every pending auto-refresh back to back, each a refresh cycle time after the last. After the final one it keeps `ref_req` high for one more refresh cycle time, then drops it and hands the bus back. Each timing value is given in nanoseconds and turned into clock cycles by rounding up.

Top module: `sdr_init_refresh`

## Requirements
- R1: From reset release until the first command, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with `sd_cke`=1, `sd_dqm`=1, `ready`=0 and `ref_req`=0.
- R2: The first command is precharge-all ({cs_n,ras_n,cas_n,we_n} = 0010, `sd_addr[10]`=1), issued HOLD_CYC cycles after reset release.
- R3: The first auto-refresh ({cs_n,ras_n,cas_n,we_n} = 0001) follows the precharge-all by exactly TRP_CYC cycles.
- R4: Exactly INIT_REFS auto-refreshes are issued during initialization, each TRFC_CYC cycles after the previous one, with only NOP in between.
- R5: The mode-register load ({cs_n,ras_n,cas_n,we_n} = 0000) follows the last initial refresh by TRFC_CYC cycles and drives `sd_addr[12:7]`=0, `sd_addr[6:0]`=`mode_op` and `sd_ba`=0.
- R6: `ready` rises TRSC_CYC cycles after the mode-register load and then stays high. `sd_dqm` goes low together with it, and no further command appears on its own.
- R7: `ref_req` rises TREFI_CYC+1 cycles after `ready` rises.
- R8: After initialization, an auto-refresh is issued only while `ref_req` is high and `ref_gnt` was sampled high. The refresh appears one cycle after the grant is first seen.
- R9: At most MAX_PEND refresh obligations are kept. After a grant that is withheld for longer than that, exactly MAX_PEND auto-refreshes are issued, spaced TRFC_CYC apart.
- R10: `ref_req` falls exactly TRFC_CYC cycles after the last pending auto-refresh. When the grant is held high constantly, successive refreshes are TREFI_CYC cycles apart.
- R11: `ref_gnt` has no effect during initialization. The sequence of R2 to R6 is unchanged when it is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_op | input | 7 | Burst and latency code loaded into the mode register |
| ref_gnt | input | 1 | User port has closed all banks and released the bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask, high during initialization |
| sd_addr | output | 13 | Address bus (A10 selects all banks on precharge) |
| sd_ba | output | 2 | Bank address |
| ready | output | 1 | Initialization complete |
| ref_req | output | 1 | Sequencer needs the bus for refresh |

## Verification
The hardest state to reach is the saturated obligation counter. It needs the grant to be withheld across more than MAX_PEND refresh intervals, followed by a burst that must not be stretched by a fresh interval tick. The bench shortens the timing parameters and waits until ten intervals have elapsed after `ready`. It grants just after a tick, so the burst ends well before the next one. It then checks the count, the spacing and the release of `ref_req`. Separate reset runs with random opcodes cover grant held high from the start and a random grant delay.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PREA = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PRE_WAIT,
    ST_INIT_REF,
    ST_MRS_WAIT,
    ST_RUN,
    ST_REF_WAIT
  } seq_state_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdr_timer.sv
`timescale 1ns/1ps
module sdr_timer #(
  parameter int          W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_pacer.sv
`timescale 1ns/1ps
module sdr_refresh_pacer #(
  parameter int unsigned PERIOD   = 1560,
  parameter int unsigned MAX_PEND = 8,
  parameter int          PW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          take,
  output logic [PW-1:0] pend
);

  localparam int IW = $clog2(PERIOD + 1);

  logic [IW-1:0] icnt_q;
  logic [PW-1:0] pend_q, after_take;
  logic          tick;

  assign tick = en && (icnt_q == IW'(PERIOD - 1));

  always_comb begin
    after_take = pend_q;
    if (take && pend_q != '0) after_take = pend_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt_q <= '0;
      pend_q <= '0;
    end else begin
      if (!en || tick) icnt_q <= '0;
      else             icnt_q <= icnt_q + 1'b1;
      if (tick && after_take < PW'(MAX_PEND)) pend_q <= after_take + 1'b1;
      else                                    pend_q <= after_take;
    end
  end

  assign pend = pend_q;

  assert_pend_limit_R9: assert property (@(posedge clk) disable iff (rst)
    pend_q <= PW'(MAX_PEND));

  assert_take_when_pending_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> pend_q != '0);

endmodule

// File: rtl/sdr_init_refresh.sv
`timescale 1ns/1ps
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned HOLD_NS   = 200000,
  parameter int unsigned TRP_NS    = 20,
  parameter int unsigned TRFC_NS   = 80,
  parameter int unsigned TRSC_NS   = 20,
  parameter int unsigned TREFI_NS  = 7800,
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned MAX_PEND  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [6:0]  mode_op,
  input  logic        ref_gnt,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic        sd_cke,
  output logic        sd_dqm,
  output logic [12:0] sd_addr,
  output logic [1:0]  sd_ba,
  output logic        ready,
  output logic        ref_req
);

  localparam int unsigned HOLD_CYC  = ns2cyc(HOLD_NS, CLK_NS);
  localparam int unsigned TRP_CYC   = ns2cyc(TRP_NS, CLK_NS);
  localparam int unsigned TRFC_CYC  = ns2cyc(TRFC_NS, CLK_NS);
  localparam int unsigned TRSC_CYC  = ns2cyc(TRSC_NS, CLK_NS);
  localparam int unsigned TREFI_CYC = ns2cyc(TREFI_NS, CLK_NS);
  localparam int TW  = $clog2(HOLD_CYC + TRP_CYC + TRFC_CYC + TRSC_CYC + 1);
  localparam int RCW = $clog2(INIT_REFS + 1);
  localparam int PW  = $clog2(MAX_PEND + 1);
  localparam int SW  = $clog2(TRFC_CYC + 1);

  seq_state_e     state_q, state_d;
  sdr_cmd_e       cmd_q, cmd_d;
  logic [12:0]    addr_q, addr_d;
  logic [RCW-1:0] icnt_q, icnt_d;
  logic           ready_q, ready_d, req_q, req_d, dqm_q, cke_q;
  logic           t_load, t_done, take;
  logic [TW-1:0]  t_val;
  logic [PW-1:0]  pend;

  sdr_timer #(.W(TW), .RST_VAL(HOLD_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  sdr_refresh_pacer #(.PERIOD(TREFI_CYC), .MAX_PEND(MAX_PEND), .PW(PW)) u_pacer (
    .clk(clk), .rst(rst), .en(ready_q), .take(take), .pend(pend)
  );

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    addr_d  = '0;
    icnt_d  = icnt_q;
    ready_d = ready_q;
    req_d   = req_q;
    t_load  = 1'b0;
    t_val   = '0;
    take    = 1'b0;
    case (state_q)
      ST_HOLD: if (t_done) begin
        cmd_d      = CMD_PREA;
        addr_d[10] = 1'b1;
        t_load     = 1'b1;
        t_val      = TW'(TRP_CYC - 1);
        state_d    = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (t_done) begin
        cmd_d   = CMD_REF;
        icnt_d  = RCW'(1);
        t_load  = 1'b1;
        t_val   = TW'(TRFC_CYC - 1);
        state_d = ST_INIT_REF;
      end
      ST_INIT_REF: if (t_done) begin
        t_load = 1'b1;
        if (int'(icnt_q) < int'(INIT_REFS)) begin
          cmd_d  = CMD_REF;
          icnt_d = icnt_q + 1'b1;
          t_val  = TW'(TRFC_CYC - 1);
        end else begin
          cmd_d   = CMD_MRS;
          addr_d  = {6'b0, mode_op};
          t_val   = TW'(TRSC_CYC - 1);
          state_d = ST_MRS_WAIT;
        end
      end
      ST_MRS_WAIT: if (t_done) begin
        ready_d = 1'b1;
        state_d = ST_RUN;
      end
      ST_RUN: if (pend != '0) begin
        req_d = 1'b1;
        if (req_q && ref_gnt) begin
          cmd_d   = CMD_REF;
          take    = 1'b1;
          t_load  = 1'b1;
          t_val   = TW'(TRFC_CYC - 1);
          state_d = ST_REF_WAIT;
        end
      end
      ST_REF_WAIT: if (t_done) begin
        if (pend == '0) begin
          req_d   = 1'b0;
          state_d = ST_RUN;
        end else if (ref_gnt) begin
          cmd_d  = CMD_REF;
          take   = 1'b1;
          t_load = 1'b1;
          t_val  = TW'(TRFC_CYC - 1);
        end else begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      icnt_q  <= '0;
      ready_q <= 1'b0;
      req_q   <= 1'b0;
      dqm_q   <= 1'b1;
      cke_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      icnt_q  <= icnt_d;
      ready_q <= ready_d;
      req_q   <= req_d;
      dqm_q   <= ~ready_d;
      cke_q   <= 1'b1;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr = addr_q;
  assign sd_ba   = 2'b00;
  assign sd_cke  = cke_q;
  assign sd_dqm  = dqm_q;
  assign ready   = ready_q;
  assign ref_req = req_q;

  // cycles since the last refresh on the pins, saturating at TRFC_CYC
  logic [SW-1:0] since_ref_q;
  always_ff @(posedge clk) begin
    if (rst)                             since_ref_q <= SW'(TRFC_CYC);
    else if (cmd_q == CMD_REF)           since_ref_q <= SW'(1);
    else if (since_ref_q < SW'(TRFC_CYC)) since_ref_q <= since_ref_q + 1'b1;
  end

  assert_ref_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |-> (since_ref_q >= SW'(TRFC_CYC)));

  assert_mrs_opcode_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (sd_addr[12:7] == 6'b0 && sd_addr[6:0] == $past(mode_op)));

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);

  assert_ref_granted_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_q && cmd_q == CMD_REF) |-> ($past(ref_gnt) && $past(req_q)));

endmodule

// File: tb/sdr_init_refresh_bench.sv
`timescale 1ns/1ps
module sdr_init_refresh_bench;

  localparam int HOLD = 100, TRP = 4, TRFC = 16, TRSC = 4, TREFI = 400;
  localparam int NREF = 8, MAXP = 8;

  logic        clk = 1'b0, rst = 1'b1, ref_gnt = 1'b0;
  logic [6:0]  mode_op = '0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm, ready, ref_req;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;

  sdr_init_refresh #(
    .CLK_NS(5), .HOLD_NS(500), .TRP_NS(20), .TRFC_NS(80), .TRSC_NS(20),
    .TREFI_NS(2000), .INIT_REFS(NREF), .MAX_PEND(MAXP)
  ) u_sdr_init_refresh (
    .clk(clk), .rst(rst), .mode_op(mode_op), .ref_gnt(ref_gnt),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .ready(ready), .ref_req(ref_req)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, nev = 0, hold_bad = 0, ready_cyc = -1;
  bit finished = 0;
  int          ev_cyc  [0:63];
  logic [3:0]  ev_cmd  [0:63];
  logic [12:0] ev_addr [0:63];
  logic [1:0]  ev_ba   [0:63];

  // monitor: cyc equals the number of rising edges since reset release
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; nev = 0; hold_bad = 0; ready_cyc = -1;
    end else begin
      logic [3:0] c;
      cyc = cyc + 1;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (c != 4'b0111) begin
        if (nev < 64) begin
          ev_cyc[nev] = cyc; ev_cmd[nev] = c; ev_addr[nev] = sd_addr; ev_ba[nev] = sd_ba;
        end
        nev = nev + 1;
      end else if (nev == 0) begin
        if (!sd_cke || !sd_dqm || ready || ref_req) hold_bad = hold_bad + 1;
      end
      if (ready && ready_cyc < 0) ready_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) step(1);
  endtask

  function automatic int exp_ref(input int i); return HOLD + TRP + i * TRFC; endfunction
  function automatic int exp_mrs(); return HOLD + TRP + NREF * TRFC; endfunction
  function automatic int exp_ready(); return exp_mrs() + TRSC; endfunction

  task automatic init_run(input logic [6:0] op, input logic gnt);
    step(1);
    rst = 1'b1; mode_op = op; ref_gnt = gnt;
    step(3);
    rst = 1'b0;
    wait_until(exp_ready() + 2);
    chk(hold_bad == 0 && sd_cke == 1'b1, "R1 hold pins", hold_bad, 0);
    chk(ev_cmd[0] == 4'b0010 && ev_addr[0][10] && ev_cyc[0] == HOLD,
        "R2 precharge-all cycle", ev_cyc[0], HOLD);
    chk(ev_cmd[1] == 4'b0001 && ev_cyc[1] == HOLD + TRP, "R3 first refresh cycle", ev_cyc[1], HOLD + TRP);
    begin
      int bad = 0;
      for (int i = 0; i < NREF; i++)
        if (ev_cmd[i+1] != 4'b0001 || ev_cyc[i+1] != exp_ref(i)) bad++;
      chk(bad == 0, "R4 init refresh count and spacing", bad, 0);
    end
    chk(ev_cmd[NREF+1] == 4'b0000 && ev_cyc[NREF+1] == exp_mrs(), "R5 mode load cycle",
        ev_cyc[NREF+1], exp_mrs());
    chk(ev_addr[NREF+1] == {6'b0, op} && ev_ba[NREF+1] == 2'b00, "R5 mode load address",
        ev_addr[NREF+1], {6'b0, op});
    chk(ready_cyc == exp_ready(), "R6 ready cycle", ready_cyc, exp_ready());
    chk(ready && !sd_dqm && nev == NREF + 2, "R6 ready, mask low, no extra command", nev, NREF + 2);
    if (gnt) chk(nev == NREF + 2, "R11 grant ignored in init", nev, NREF + 2);
  endtask

  initial begin : wd
    #(100000 * 5);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    int r, g, base;
    void'($urandom(32'd20240611));

    // run A: grant held high throughout
    init_run(7'($urandom_range(0, 127)), 1'b1);
    r = ready_cyc;
    wait_until(r + 3 * TREFI + 2 + TRFC + 4);
    chk(nev == NREF + 5, "R10 periodic refresh count", nev, NREF + 5);
    chk(ev_cmd[NREF+2] == 4'b0001 && ev_cyc[NREF+2] == r + TREFI + 2, "R7 first periodic refresh",
        ev_cyc[NREF+2], r + TREFI + 2);
    chk(ev_cyc[NREF+3] - ev_cyc[NREF+2] == TREFI && ev_cyc[NREF+4] - ev_cyc[NREF+3] == TREFI,
        "R10 periodic spacing", ev_cyc[NREF+3] - ev_cyc[NREF+2], TREFI);
    chk(ref_req == 1'b0, "R10 request released between intervals", ref_req, 0);

    // run B: random grant delay
    init_run(7'($urandom_range(0, 127)), 1'b0);
    r = ready_cyc;
    while (!ref_req && cyc < r + 2 * TREFI) step(1);
    chk(cyc == r + TREFI + 1, "R7 request rise cycle", cyc, r + TREFI + 1);
    step(int'($urandom_range(3, 30)));
    chk(nev == NREF + 2 && ref_req, "R8 no refresh without grant", nev, NREF + 2);
    g = cyc;
    ref_gnt = 1'b1;
    step(1);
    chk(nev == NREF + 3 && ev_cyc[NREF+2] == g + 1, "R8 refresh one cycle after grant",
        ev_cyc[NREF+2], g + 1);
    wait_until(g + TRFC);
    chk(ref_req == 1'b1, "R10 request held during refresh cycle time", ref_req, 1);
    step(1);
    chk(ref_req == 1'b0, "R10 request falls after refresh cycle time", ref_req, 0);
    ref_gnt = 1'b0;

    // run C: grant withheld past saturation
    init_run(7'($urandom_range(0, 127)), 1'b0);
    r = ready_cyc;
    wait_until(r + (MAXP + 2) * TREFI + 5);
    chk(ref_req && nev == NREF + 2, "R8 requests pile up without refresh", nev, NREF + 2);
    g = cyc;
    ref_gnt = 1'b1;
    wait_until(g + 1 + MAXP * TRFC + 2);
    chk(nev == NREF + 2 + MAXP, "R9 saturated burst length", nev - NREF - 2, MAXP);
    begin
      int bad = 0;
      base = NREF + 2;
      for (int j = 0; j < MAXP; j++)
        if (ev_cmd[base+j] != 4'b0001 || ev_cyc[base+j] != g + 1 + j * TRFC) bad++;
      chk(bad == 0, "R9 burst spacing", bad, 0);
    end
    chk(ref_req == 1'b0, "R10 request released after burst", ref_req, 1'b0);
    ref_gnt = 1'b0;
    step(50);
    chk(nev == NREF + 2 + MAXP, "R8 no refresh after grant drops", nev, NREF + 2 + MAXP);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule